// File: doc/BRIEF.md
# Event-Driven Detector Readout Sequencer

This block is the digital controller for one particle-detector channel. It watches two asynchronous discriminator levels: the main channel and a coincidence channel. A configuration setting can make the main trigger depend on the coincidence channel. In coincidence mode the main trigger needs a coincidence edge near it. In anti-coincidence mode such an edge vetoes the main trigger. When an event is accepted, the sequencer asks the analog side to detect the peak and hold it. It then waits for the held value to be latched.

Only a small trigger section runs all the time. The conversion registers and the output stay still until the held value is latched. The conversion then runs in two steps. A coarse strobe returns the upper nibble of the code, and a fine strobe afterwards returns the lower nibble. The 8-bit code is either registered and held for a bus reader, or driven straight from the working registers. A one-cycle data-valid pulse marks each finished code. A main trigger that arrives while the sequencer is busy is dropped and raises a sticky pile-up flag.

Top module: `det_readout_seq`

## Requirements
- R1: `main_raw_o` and `coin_raw_o` equal `main_disc_i` and `coin_disc_i` combinationally, with no clock delay.
- R2: With the gate-enable bit (`cfg_wdata[0]`) clear, every main rising edge seen while idle is accepted and asserts `peak_arm_o`. This is the state after reset.
- R3: With gate enable set and the mode bit (`cfg_wdata[1]`) clear, a main edge is accepted only if a coincidence rising edge falls within W clock cycles before or after it. W is `cfg_wdata[6:3]`, from 0 to 15.
- R4: With gate enable set and the mode bit set, a main edge is vetoed exactly when a coincidence rising edge falls within that same W-cycle window. Otherwise it is accepted.
- R5: Neither conversion strobe fires and the working conversion registers do not change until a rising edge of `held_i` arrives while `peak_arm_o` is high. The coarse strobe follows that edge.
- R6: `cmp_code_i` is sampled one cycle after each strobe. The coarse code becomes bits [7:4] of the result and the fine code becomes bits [3:0]. The fine strobe comes two cycles after the coarse strobe.
- R7: `dvalid_o` is high for exactly one cycle per event, and `data_o` carries the result in that cycle. In the next cycle `busy_o` is low and a new trigger is accepted.
- R8: With the latch bit (`cfg_wdata[2]`) set, `data_o` holds the last finished result until the next `dvalid_o`, including through the next conversion.
- R9: With the latch bit clear, `data_o` follows the working registers, so bits [7:4] take the new coarse code during a conversion.
- R10: A main rising edge while `busy_o` is high does not disturb the event in progress and sets `pileup_o`. The flag stays set until the next configuration write.
- R11: After reset, `busy_o`, `peak_arm_o`, `dvalid_o`, `pileup_o` and `data_o` are zero, and the configuration is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (4 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe; also clears the pile-up flag |
| cfg_wdata | input | 7 | {window[3:0], latch, anti, gate_en} |
| main_disc_i | input | 1 | Asynchronous main discriminator level |
| coin_disc_i | input | 1 | Asynchronous coincidence discriminator level |
| held_i | input | 1 | Asynchronous "peak held" level from the sample-and-hold stage |
| cmp_code_i | input | 4 | Nibble returned by the comparator model |
| main_raw_o | output | 1 | Unregistered copy of the main discriminator level |
| coin_raw_o | output | 1 | Unregistered copy of the coincidence discriminator level |
| peak_arm_o | output | 1 | Peak-detect and hold command |
| conv_coarse_o | output | 1 | Coarse conversion step strobe |
| conv_fine_o | output | 1 | Fine conversion step strobe |
| busy_o | output | 1 | High from trigger until the cycle after the result is valid |
| dvalid_o | output | 1 | One-cycle result-valid pulse |
| data_o | output | 8 | Conversion result |
| pileup_o | output | 1 | Sticky pile-up flag |

## Verification
The assertions check the sequence rules on every cycle:
- the coarse strobe needs a held edge while armed;
- the fine strobe lags the coarse strobe, and data-valid lags the fine strobe, by fixed distances;
- data-valid is a single pulse;
- the working registers stay still while idle;
- latched output is stable between results;
- the pile-up flag changes only through its two causes.

Whether the coincidence decision is right for a given edge spacing, window and mode, and whether the result nibbles land in the right place, can only be shown by the bench. It sweeps edge offsets from −6 to +6 cycles over several windows and all gating modes, and compares the result with codes it chose itself.

// File: rtl/readout_pkg.sv
package readout_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN,
    ST_ARM,
    ST_CSTR,
    ST_CCAP,
    ST_FSTR,
    ST_FCAP,
    ST_DONE
  } seq_state_t;

  // Trigger acceptance: ungated passes always; otherwise coincidence
  // needs a hit and anti-coincidence needs its absence.
  function automatic logic gate_pass(input logic gate_en, input logic anti,
                                     input logic hit);
    return !gate_en || (anti ? !hit : hit);
  endfunction

  // Saturating increment for the edge-age counter.
  function automatic logic [7:0] sat_inc(input logic [7:0] val,
                                         input logic [7:0] max_v);
    return (val == max_v) ? val : val + 8'd1;
  endfunction

endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/rs_coin_window.sv
module rs_coin_window #(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coin_rise,
  input  logic             start,
  input  logic             in_win,
  input  logic [WIN_W-1:0] win_len,
  output logic             start_hit_o,
  output logic             seen_now_o,
  output logic             win_done_o
);

  localparam int AGE_W = WIN_W + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] age_q;
  logic [WIN_W-1:0] cnt_q;
  logic             seen_q;
  logic [7:0]       age_next;

  // age_q = cycles since the last coincidence edge (saturating)
  assign age_next = readout_pkg::sat_inc(8'(age_q), 8'(AGE_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= AGE_MAX;
    end else if (coin_rise) begin
      age_q <= AGE_W'(1);
    end else begin
      age_q <= age_next[AGE_W-1:0];
    end
  end

  assign start_hit_o = coin_rise || (age_q <= {1'b0, win_len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= WIN_W'(1);
      seen_q <= start_hit_o;
    end else if (in_win) begin
      cnt_q  <= cnt_q + WIN_W'(1);
      seen_q <= seen_q | coin_rise;
    end
  end

  assign seen_now_o = seen_q | coin_rise;
  assign win_done_o = in_win && (cnt_q == win_len);

endmodule

// File: rtl/rs_conv.sv
module rs_conv #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_hi,
  input  logic                cap_lo,
  input  logic [DATA_W/2-1:0] code_i,
  input  logic                latched,
  output logic [DATA_W-1:0]   data_o,
  output logic [DATA_W-1:0]   work_o
);

  localparam int NIB_W = DATA_W / 2;

  logic [NIB_W-1:0]  hi_q, lo_q;
  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      out_q <= '0;
    end else begin
      if (cap_hi) hi_q <= code_i;
      if (cap_lo) begin
        lo_q  <= code_i;
        out_q <= {hi_q, code_i};
      end
    end
  end

  assign work_o = {hi_q, lo_q};
  assign data_o = latched ? out_q : work_o;

endmodule

// File: rtl/det_readout_seq.sv
module det_readout_seq
  import readout_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int WIN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [WIN_W+2:0]    cfg_wdata,
  input  logic                main_disc_i,
  input  logic                coin_disc_i,
  input  logic                held_i,
  input  logic [DATA_W/2-1:0] cmp_code_i,
  output logic                main_raw_o,
  output logic                coin_raw_o,
  output logic                peak_arm_o,
  output logic                conv_coarse_o,
  output logic                conv_fine_o,
  output logic                busy_o,
  output logic                dvalid_o,
  output logic [DATA_W-1:0]   data_o,
  output logic                pileup_o
);

  localparam int CFG_W     = WIN_W + 3;
  localparam int GATE_BIT  = 0;
  localparam int ANTI_BIT  = 1;
  localparam int LATCH_BIT = 2;
  localparam int WIN_LSB   = 3;

  // configuration
  logic [CFG_W-1:0] cfg_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  logic             cfg_gate, cfg_anti, cfg_latched;
  logic [WIN_W-1:0] win_len;
  assign cfg_gate    = cfg_q[GATE_BIT];
  assign cfg_anti    = cfg_q[ANTI_BIT];
  assign cfg_latched = cfg_q[LATCH_BIT];
  assign win_len     = cfg_q[WIN_LSB +: WIN_W];

  // always-on trigger section: synchronisers and edge detection
  logic [2:0] sync_w, prev_q, rise_w;
  rs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({held_i, coin_disc_i, main_disc_i}),
    .sync_o  (sync_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_w;
  end

  assign rise_w = sync_w & ~prev_q;

  logic main_rise, coin_rise, held_rise;
  assign main_rise = rise_w[0];
  assign coin_rise = rise_w[1];
  assign held_rise = rise_w[2];

  // sequencer state
  seq_state_t st_q, st_nxt;
  logic start_w, in_win_w, start_hit_w, seen_now_w, win_done_w;

  assign start_w  = (st_q == ST_IDLE) && main_rise;
  assign in_win_w = (st_q == ST_WIN);

  rs_coin_window #(.WIN_W(WIN_W)) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .coin_rise   (coin_rise),
    .start       (start_w),
    .in_win      (in_win_w),
    .win_len     (win_len),
    .start_hit_o (start_hit_w),
    .seen_now_o  (seen_now_w),
    .win_done_o  (win_done_w)
  );

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (main_rise) begin
          if (!cfg_gate)
            st_nxt = ST_ARM;
          else if (win_len == '0)
            st_nxt = gate_pass(1'b1, cfg_anti, start_hit_w) ? ST_ARM : ST_IDLE;
          else
            st_nxt = ST_WIN;
        end
      end
      ST_WIN: begin
        if (win_done_w)
          st_nxt = gate_pass(cfg_gate, cfg_anti, seen_now_w) ? ST_ARM : ST_IDLE;
      end
      ST_ARM:  if (held_rise) st_nxt = ST_CSTR;
      ST_CSTR: st_nxt = ST_CCAP;
      ST_CCAP: st_nxt = ST_FSTR;
      ST_FSTR: st_nxt = ST_FCAP;
      ST_FCAP: st_nxt = ST_DONE;
      ST_DONE: st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nxt;
  end

  // pile-up flag: sticky, cleared by a configuration write
  logic pileup_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pileup_q <= 1'b0;
    else if (cfg_we)                     pileup_q <= 1'b0;
    else if (main_rise && busy_o)        pileup_q <= 1'b1;
  end

  // conversion datapath: quiet until the held value is latched
  logic [DATA_W-1:0] conv_work;
  rs_conv #(.DATA_W(DATA_W)) u_conv (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_hi  (st_q == ST_CCAP),
    .cap_lo  (st_q == ST_FCAP),
    .code_i  (cmp_code_i),
    .latched (cfg_latched),
    .data_o  (data_o),
    .work_o  (conv_work)
  );

  assign main_raw_o    = main_disc_i;
  assign coin_raw_o    = coin_disc_i;
  assign busy_o        = (st_q != ST_IDLE);
  assign peak_arm_o    = (st_q == ST_ARM);
  assign conv_coarse_o = (st_q == ST_CSTR);
  assign conv_fine_o   = (st_q == ST_FSTR);
  assign dvalid_o      = (st_q == ST_DONE);
  assign pileup_o      = pileup_q;

endmodule

// File: rtl/rs_seq_checker.sv
module rs_seq_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              dvalid,
  input logic              coarse,
  input logic              fine,
  input logic              arm,
  input logic              held_rise,
  input logic              main_rise,
  input logic              pileup,
  input logic              cfg_we,
  input logic              latched,
  input logic [DATA_W-1:0] data,
  input logic [DATA_W-1:0] work
);

  p_coarse_after_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    coarse |-> $past(held_rise && arm));

  p_quiet_work_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $stable(work));

  p_fine_after_coarse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fine |-> $past(coarse, 2));

  p_valid_after_fine_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> $past(fine, 2));

  p_single_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |=> (!dvalid && !busy));

  p_latched_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && $past(latched) && !dvalid) |-> $stable(data));

  p_pileup_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pileup) |-> $past(main_rise && busy));

  p_pileup_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pileup) |-> $past(cfg_we));

endmodule

bind det_readout_seq rs_seq_checker #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy_o),
  .dvalid    (dvalid_o),
  .coarse    (conv_coarse_o),
  .fine      (conv_fine_o),
  .arm       (peak_arm_o),
  .held_rise (held_rise),
  .main_rise (main_rise),
  .pileup    (pileup_o),
  .cfg_we    (cfg_we),
  .latched   (cfg_latched),
  .data      (data_o),
  .work      (conv_work)
);

// File: tb/det_readout_seq_tb.sv
module det_readout_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [6:0] cfg_wdata;
  logic       main_d, coin_d, held;
  logic [3:0] cmp_code;
  logic       main_raw, coin_raw, arm, coarse, fine, busy, dvalid, pileup;
  logic [7:0] data;

  int checks = 0;
  int errors = 0;
  int prev_result = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  det_readout_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .main_disc_i(main_d), .coin_disc_i(coin_d), .held_i(held),
    .cmp_code_i(cmp_code), .main_raw_o(main_raw), .coin_raw_o(coin_raw),
    .peak_arm_o(arm), .conv_coarse_o(coarse), .conv_fine_o(fine),
    .busy_o(busy), .dvalid_o(dvalid), .data_o(data), .pileup_o(pileup)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cfg_write(bit g, bit a, bit l, int w);
    tick();
    cfg_we    = 1'b1;
    cfg_wdata = {w[3:0], l, a, g};
    tick();
    cfg_we    = 1'b0;
  endtask

  // d > 0: coincidence edge d cycles before main; d < 0: after main
  task automatic run_event(int d, int w, bit g, bit a, bit l,
                           int cc, int cf, bit pile);
    int  ad      = (d < 0) ? -d : d;
    bit  hit     = (ad <= w);
    bit  exp_acc = !g || (a ? !hit : hit);
    int  m0      = (d >= 0) ? d : 0;
    int  c0      = (d >= 0) ? 0 : -d;
    bit  seen_arm = 0;
    bit  early    = 0;
    bit  seen_c   = 0;
    int  nvalid   = 0;
    for (int k = 0; k < ad + 3; k++) begin
      tick();
      if (arm) seen_arm = 1;
      if (coarse || fine) early = 1;
      main_d = (k >= m0) && (k < m0 + 2);
      coin_d = (k >= c0) && (k < c0 + 2);
      if (k == m0) begin
        #1;
        chk("R1 main raw", main_raw, 1);
        chk("R1 coin raw", coin_raw, coin_d);
      end
    end
    main_d = 1'b0;
    coin_d = 1'b0;
    for (int k = 0; k < 30; k++) begin
      tick();
      if (arm) seen_arm = 1;
      if (coarse || fine) early = 1;
    end
    if (!g) chk("R2 ungated accept", seen_arm, 1);
    else if (!a) chk("R3 coincidence accept", seen_arm, exp_acc);
    else chk("R4 anti-coincidence accept", seen_arm, exp_acc);
    chk("R5 no strobe before held", early, 0);
    if (seen_arm) begin
      if (pile) begin
        tick(); main_d = 1'b1;
        tick(); tick(); main_d = 1'b0;
        repeat (4) tick();
        chk("R10 pileup set", pileup, 1);
        chk("R10 still armed", arm, 1);
      end
      held = 1'b1;
      for (int k = 0; k < 40; k++) begin
        tick();
        if (coarse) begin
          cmp_code = cc[3:0];
          seen_c = 1;
        end
        if (fine) begin
          cmp_code = cf[3:0];
          chk("R6 coarse before fine", seen_c, 1);
          if (l) chk("R8 latched holds during conversion", data, prev_result);
          else   chk("R9 direct shows coarse nibble", data[7:4], cc);
        end
        if (dvalid) begin
          nvalid++;
          chk("R6 result nibbles", data, (cc << 4) | cf);
        end
      end
      chk("R7 one valid pulse", nvalid, 1);
      chk("R7 idle after result", busy, 0);
      chk("R7 result still on output", data, (cc << 4) | cf);
      prev_result = (cc << 4) | cf;
      held = 1'b0;
    end
    repeat (40) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int trial = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    main_d = 1'b0; coin_d = 1'b0; held = 1'b0; cmp_code = '0;
    repeat (3) tick();
    chk("R11 busy reset", busy, 0);
    chk("R11 arm reset", arm, 0);
    chk("R11 dvalid reset", dvalid, 0);
    chk("R11 pileup reset", pileup, 0);
    chk("R11 data reset", data, 0);
    rst_n = 1'b1;
    repeat (3) tick();

    // default configuration: ungated, direct
    run_event(3, 0, 0, 0, 0, 9, 6, 0);

    for (int mode = 0; mode < 3; mode++) begin
      for (int wi = 0; wi < 3; wi++) begin
        for (int d = -6; d <= 6; d++) begin
          int w  = (wi == 0) ? 0 : (wi == 1) ? 2 : 5;
          bit g  = (mode != 0);
          bit a  = (mode == 2);
          bit l  = trial[0];
          int cc = trial % 16;
          int cf = (trial * 7 + 3) % 16;
          cfg_write(g, a, l, w);
          run_event(d, w, g, a, l, cc, cf, 0);
          trial++;
        end
      end
    end

    // pile-up during an event, then clear by a write (R10)
    cfg_write(0, 0, 1, 0);
    run_event(0, 0, 0, 0, 1, 5, 10, 1);
    chk("R10 pileup sticky", pileup, 1);
    cfg_write(0, 0, 1, 0);
    tick();
    chk("R10 pileup cleared", pileup, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule